// File: doc/BRIEF.md
# Synchronous Clock Output Controller

This block turns one fast core clock into the level streams for a family of board clock outputs. It drives a CPU-rate pair, seven PCI-rate outputs divided from the CPU rate, a fixed USB-rate output and a selectable 24/48 output. The CPU output toggles on every advance of the core, which gives half the core rate. The PCI outputs divide that CPU clock by three in the high-frequency mode and by two in the low-frequency mode, so the PCI rate stays near 33 MHz in both modes. The USB-rate output toggles on cycles marked by a separate advance strobe. The 24/48 output is either a copy of the USB-rate output or that output divided by two. A strap input chooses between them. It is sampled once, a fixed number of cycles after reset.

Each output has its own disable bit, and a disabled output is held low. A disable or an enable is applied only while that output is low, so the block never emits a truncated high pulse. A global three-state control removes all output enables. A bypass test mode makes every divider advance on rising edges of a reference input instead of on the core clock and the USB strobe. PLL synthesis and the analog drivers lie outside this block.

Top module: `clk_out_ctrl`

## Requirements
- R1: While reset is asserted, all clock outputs are low and all output enables are low. On release, every output is enabled.
- R2: Outputs 0 and 1 form the CPU pair. They carry identical levels, and the level toggles on every advance. An advance is every core cycle in normal mode.
- R3: Outputs 2 to 8 are the PCI outputs, and output 2 is the free-running copy. With freq_sel=1 they have a period of 6 advances (3 high, 3 low). With freq_sel=0 they have a period of 4 advances (2 high, 2 low). Every PCI rising edge coincides with a CPU rising edge.
- R4: At any clock edge where freq_sel differs from its value at the previous edge, the CPU and PCI dividers return to the reset phase, with both outputs low. Counting restarts from there.
- R5: Output 9 is the USB-rate output. It toggles on each cycle in which usb_adv is high.
- R6: strap_in is latched at the STRAP_CYC-th clock edge after reset and is not sampled again until the next reset. Before the latch, output 10 is low. Afterwards, a latched 0 makes output 10 equal to output 9, and a latched 1 makes output 10 toggle on each rising edge of the USB-rate clock.
- R7: Bit i of out_dis controls output i. While a bit is set, that output is held low.
- R8: A change of an output's enable state takes effect only at an edge after which that output's undisabled level is low. High pulses are therefore never shortened.
- R9: One cycle after three_state is high, every bit of out_oe is 0. One cycle after it falls, every bit is 1 again. The clock levels are not affected.
- R10: With bypass=1, the CPU, PCI and USB dividers advance only at edges where ref_in is sampled high after being low at the previous edge. usb_adv is ignored in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 1 | 1: CPU/PCI = 3, 0: CPU/PCI = 2 |
| usb_adv | input | 1 | Advance strobe for the USB-rate output |
| ref_in | input | 1 | Reference clock used in bypass mode |
| bypass | input | 1 | Test mode: advance on ref_in rising edges |
| three_state | input | 1 | Global output-enable removal |
| strap_in | input | 1 | 24/48 rate strap, latched once after reset |
| out_dis | input | 11 | Per-output disable, bit i for output i |
| clk_o | output | 11 | Clock output levels |
| out_oe | output | 11 | Clock output enables |

## Verification
The embedded assertions check, on every cycle, several per-edge properties. They cover the CPU toggle on each advance, the coincidence of PCI rising edges with CPU rising edges, and the return to phase zero after a frequency-select change. They also check that an enable register only moves while its output is low, that the strap stays frozen once latched, and that output enables are removed after a three-state request. The bench's scenarios are needed for the rest. These are the actual PCI periods in each mode, the choice between the two 24/48 rates across two resets with different straps, and advancement on reference edges in bypass. They also include the combined behaviour of random disable patterns against a cycle model.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int N_CPU   = 2;
  localparam int N_PCI   = 7;
  localparam int N_OUT   = N_CPU + N_PCI + 2;
  localparam int IDX_CPU = 0;
  localparam int IDX_PCI = N_CPU;
  localparam int IDX_USB = N_CPU + N_PCI;
  localparam int IDX_SEL = N_CPU + N_PCI + 1;
endpackage

// File: rtl/cpu_pci_div.sv
module cpu_pci_div #(
  parameter int DIV_HI = 3,
  parameter int DIV_LO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_sel,
  input  logic adv,
  output logic cpu_q,
  output logic cpu_d,
  output logic pci_q,
  output logic pci_d
);
  localparam int CW = $clog2(2 * DIV_HI + 1);

  logic          sel_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] half_len, last_cnt;
  logic          realign;

  always_comb begin
    half_len = freq_sel ? CW'(DIV_HI) : CW'(DIV_LO);
    last_cnt = freq_sel ? CW'(2 * DIV_HI - 1) : CW'(2 * DIV_LO - 1);
    realign  = (freq_sel != sel_q);
    cnt_d    = cnt_q;
    cpu_d    = cpu_q;
    pci_d    = pci_q;
    if (realign) begin
      cnt_d = '0;
      cpu_d = 1'b0;
      pci_d = 1'b0;
    end else if (adv) begin
      cpu_d = ~cpu_q;
      cnt_d = (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
      pci_d = (cnt_d != '0) && (cnt_d <= half_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
      cpu_q <= 1'b0;
      pci_q <= 1'b0;
    end else begin
      sel_q <= freq_sel;
      cnt_q <= cnt_d;
      cpu_q <= cpu_d;
      pci_q <= pci_d;
    end
  end

  // R2
  cpu_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !realign) |=> (cpu_q != $past(cpu_q)));
  // R3
  pci_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_q) |-> $rose(cpu_q));
  // R4
  realign_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (cnt_q == '0 && !cpu_q && !pci_q));
endmodule

// File: rtl/usb_strap_div.sv
module usb_strap_div #(
  parameter int STRAP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uadv,
  input  logic strap_in,
  output logic usb_q,
  output logic usb_d,
  output logic sel_q,
  output logic sel_d
);
  localparam int SW = $clog2(STRAP_CYC + 1);

  logic          half_q, half_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          done_q, done_d;
  logic          strap_q, strap_d;

  always_comb begin
    usb_d   = usb_q;
    half_d  = half_q;
    scnt_d  = scnt_q;
    done_d  = done_q;
    strap_d = strap_q;
    if (uadv) begin
      usb_d = ~usb_q;
      if (!usb_q) half_d = ~half_q;
    end
    if (!done_q) begin
      if (scnt_q == SW'(STRAP_CYC - 1)) begin
        done_d  = 1'b1;
        strap_d = strap_in;
      end else begin
        scnt_d = scnt_q + 1'b1;
      end
    end
    sel_d = done_d && (strap_d ? half_d : usb_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_q   <= 1'b0;
      half_q  <= 1'b0;
      scnt_q  <= '0;
      done_q  <= 1'b0;
      strap_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      usb_q   <= usb_d;
      half_q  <= half_d;
      scnt_q  <= scnt_d;
      done_q  <= done_d;
      strap_q <= strap_d;
      sel_q   <= sel_d;
    end
  end

  // R5
  usb_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uadv |=> (usb_q != $past(usb_q)));
  // R6
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && $stable(strap_q)));
  // R6
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> !sel_q);
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_q,
  input  logic raw_d,
  input  logic dis,
  output logic out
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (!raw_d) en_d = ~dis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign out = raw_q & en_q;

  // R8
  gate_switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> !raw_q);
endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clk_ctl_pkg::*;
#(
  parameter int STRAP_CYC = 16,
  parameter int DIV_HI    = 3,
  parameter int DIV_LO    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freq_sel,
  input  logic             usb_adv,
  input  logic             ref_in,
  input  logic             bypass,
  input  logic             three_state,
  input  logic             strap_in,
  input  logic [N_OUT-1:0] out_dis,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] out_oe
);
  logic             ref_q, ref_rise;
  logic             adv, uadv;
  logic             oe_q;
  logic             cpu_q, cpu_d, pci_q, pci_d;
  logic             usb_q, usb_d, sel_q, sel_d;
  logic [N_OUT-1:0] raw_q, raw_d;

  always_comb begin
    ref_rise = ref_in & ~ref_q;
    adv      = bypass ? ref_rise : 1'b1;
    uadv     = bypass ? ref_rise : usb_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      oe_q  <= ~three_state;
    end
  end

  cpu_pci_div #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) div_i (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .adv(adv),
    .cpu_q(cpu_q), .cpu_d(cpu_d), .pci_q(pci_q), .pci_d(pci_d)
  );

  usb_strap_div #(.STRAP_CYC(STRAP_CYC)) usb_i (
    .clk(clk), .rst_n(rst_n), .uadv(uadv), .strap_in(strap_in),
    .usb_q(usb_q), .usb_d(usb_d), .sel_q(sel_q), .sel_d(sel_d)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out
      if (gi < IDX_PCI) begin : g_cpu
        assign raw_q[gi] = cpu_q;
        assign raw_d[gi] = cpu_d;
      end else if (gi < IDX_USB) begin : g_pci
        assign raw_q[gi] = pci_q;
        assign raw_d[gi] = pci_d;
      end else if (gi == IDX_USB) begin : g_usb
        assign raw_q[gi] = usb_q;
        assign raw_d[gi] = usb_d;
      end else begin : g_sel
        assign raw_q[gi] = sel_q;
        assign raw_d[gi] = sel_d;
      end
      out_gate gate_i (
        .clk(clk), .rst_n(rst_n), .raw_q(raw_q[gi]), .raw_d(raw_d[gi]),
        .dis(out_dis[gi]), .out(clk_o[gi])
      );
    end
  endgenerate

  assign out_oe = {N_OUT{oe_q}};

  // R9
  three_state_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    three_state |=> (out_oe == '0));
  // R9
  release_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !three_state |=> (out_oe == '1));
endmodule

// File: tb/clk_out_ctrl_tb_top.sv
module clk_out_ctrl_tb_top;
  localparam int NO    = 11;
  localparam int STRAP = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          freq_sel, usb_adv, ref_in, bypass, three_state, strap_in;
  logic [NO-1:0] out_dis;
  logic [NO-1:0] clk_o, out_oe;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clk_out_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .usb_adv(usb_adv),
    .ref_in(ref_in), .bypass(bypass), .three_state(three_state),
    .strap_in(strap_in), .out_dis(out_dis), .clk_o(clk_o), .out_oe(out_oe)
  );

  // Bench cycle model, built from the requirements
  int            m_k, m_scnt;
  bit            m_psel, m_pref, m_usb, m_half, m_done, m_strap, m_oe;
  bit [NO-1:0]   m_raw, m_en;

  function automatic bit pci_level(int k, bit sel);
    int p = sel ? 6 : 4;
    int r = k % p;
    return (r >= 1) && (r <= p / 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_scnt = 0; m_psel = 0; m_pref = 0; m_usb = 0; m_half = 0;
      m_done = 0; m_strap = 0; m_oe = 0; m_raw = '0; m_en = '1;
    end else begin
      bit rise, a, ua, o10;
      rise = ref_in && !m_pref;
      a    = bypass ? rise : 1'b1;
      ua   = bypass ? rise : usb_adv;
      if (freq_sel != m_psel) m_k = 0;
      else if (a) m_k = (m_k + 1) % 12;
      if (ua) begin
        if (!m_usb) m_half = !m_half;
        m_usb = !m_usb;
      end
      if (!m_done) begin
        if (m_scnt == STRAP - 1) begin m_done = 1; m_strap = strap_in; end
        else m_scnt++;
      end
      o10 = m_done && (m_strap ? m_half : m_usb);
      for (int i = 0; i < NO; i++) begin
        if (i < 2)       m_raw[i] = (m_k % 2) == 1;
        else if (i < 9)  m_raw[i] = pci_level(m_k, freq_sel);
        else if (i == 9) m_raw[i] = m_usb;
        else             m_raw[i] = o10;
        if (!m_raw[i]) m_en[i] = !out_dis[i];
      end
      m_oe   = !three_state;
      m_psel = freq_sel;
      m_pref = ref_in;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [NO-1:0] act,
                       input logic [NO-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [NO-1:0] e;
    e = m_raw & m_en;
    check(clk_o[1:0] == e[1:0], "R2 R7 R8 cpu pair", clk_o, e);
    check(clk_o[8:2] == e[8:2], "R3 R4 R7 R8 pci", clk_o, e);
    check(clk_o[9] == e[9], "R5 R10 usb", clk_o, e);
    check(clk_o[10] == e[10], "R6 sel output", clk_o, e);
    check(out_oe == {NO{m_oe}}, "R9 enables", out_oe, {NO{m_oe}});
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; freq_sel = 1'b1; usb_adv = 1'b0; ref_in = 1'b0;
    bypass = 1'b0; three_state = 1'b0; strap_in = strap; out_dis = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(clk_o == '0, "R1 outputs in reset", clk_o, '0);
    check(out_oe == '0, "R1 enables in reset", out_oe, '0);
    rst_n = 1'b1;
  endtask

  task automatic random_run(input int n, input bit byp);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cmp_model();
      bypass  = byp;
      usb_adv = ($urandom % 3) != 0;
      ref_in  = byp ? 1'($urandom % 2) : 1'b0;
      strap_in = 1'($urandom % 2);
      if ($urandom % 40 == 0) freq_sel = !freq_sel;
      if ($urandom % 30 == 0) three_state = !three_state;
      if ($urandom % 20 == 0) out_dis = NO'($urandom) & NO'($urandom) & NO'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd20241));
    // first life: strap 1 selects the halved rate
    do_reset(1'b1);
    repeat (5) @(negedge clk);
    check(clk_o[10] == 1'b0, "R6 low before latch", clk_o, '0);
    random_run(1500, 1'b0);

    // R4 directed: select flip returns dividers to phase zero
    out_dis = '0; three_state = 1'b0;
    repeat (12) @(negedge clk);
    freq_sel = !freq_sel;
    @(negedge clk);
    check(clk_o[8:0] == '0, "R4 realign", clk_o, '0);
    cmp_model();

    // R7 directed: all disabled for a while
    out_dis = '1;
    repeat (12) @(negedge clk);
    check(clk_o == '0, "R7 all held low", clk_o, '0);
    out_dis = '0;

    // R9 directed
    three_state = 1'b1;
    @(negedge clk);
    check(out_oe == '0, "R9 three-state", out_oe, '0);
    three_state = 1'b0;
    @(negedge clk);
    check(out_oe == '1, "R9 release", out_oe, '1);

    // R10 directed: bypass with a still reference freezes the dividers
    bypass = 1'b1; ref_in = 1'b0; usb_adv = 1'b1;
    @(negedge clk);
    begin
      logic [NO-1:0] snap;
      snap = clk_o;
      repeat (10) @(negedge clk);
      check(clk_o == snap, "R10 no reference edge", clk_o, snap);
    end
    random_run(1500, 1'b1);

    // second life: strap 0 selects the direct rate
    do_reset(1'b0);
    random_run(1500, 1'b0);
    random_run(500, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule